// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. After reset it waits a fixed pause with the memory untouched. It then runs a fixed number of column-before-row refresh cycles. Only after those does it raise `ready`, which tells the access controller that host traffic may begin. From then on an interval timer marks each moment a refresh falls due. Every expiry adds one to a small backlog counter, and the block requests the bus for as long as that backlog is non-zero.

The access controller arbitrates. When it answers a request with a grant, the sequencer takes the memory strobes for one whole refresh cycle. It pulls both byte column strobes low first, then lowers the row strobe, holds that state, and finally raises everything for precharge. The row address comes from the memory's internal counter, so the block drives no address, data, write or output-enable lines. A long page-mode burst by the controller only lets the backlog grow, up to its cap. The missed refreshes are then run back to back once the bus is granted again.

All times are parameters in clock cycles. The defaults suit a 100 MHz clock: a 200 µs pause, 8 initialization cycles, one refresh due every 15.6 µs, a backlog of at most 8, column strobes leading the row strobe by 1 cycle, a 6-cycle row-low time and a 4-cycle precharge.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `ras_n` is 1, `cas_n` is 2'b11, and `ref_req`, `ready` and `bus_own` are 0.
- R2: After reset is released, `ref_req` stays low and the strobes stay idle for exactly PAUSE_CYC clock edges. `ref_req` is first seen high after edge PAUSE_CYC.
- R3: Exactly INIT_CNT refresh cycles (falling edges of `ras_n`) run before `ready` rises. `ready` rises on the edge that ends the last of them, and the whole sequence runs again after every reset.
- R4: Each refresh cycle has three phases. First, `cas_n`=00 with `ras_n`=1 for CAS_LEAD cycles. Next, `cas_n`=00 with `ras_n`=0 for RAS_LOW cycles. Last, both strobes high for PRECH cycles. `ras_n` is never low unless both column strobes are low.
- R5: The two column strobes, bit 1 for the upper byte and bit 0 for the lower byte, always carry the same value.
- R6: Once `ready` is high, one refresh falls due every REF_INTERVAL clock cycles, counting from the edge on which `ready` rose.
- R7: Each due refresh adds one to a backlog and each completed refresh after `ready` removes one. The backlog saturates at MAX_PEND, and refreshes are never lost while it is below the cap.
- R8: `ref_req` is high exactly when initialization cycles remain, the backlog is non-zero, or a refresh cycle is in progress.
- R9: A refresh cycle starts on the edge after a cycle in which `ref_req` and `ref_gnt` are both high while the block is idle. Once it has started, `ref_gnt` has no effect until the cycle ends.
- R10: `bus_own` is high exactly while a refresh cycle is in any of its three phases. Between two cycles there is at least one idle clock.
- R11: Once `ready` is high it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the power-up sequence |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | Bus request to the access controller |
| ready | output | 1 | High once the pause and initialization cycles have completed |
| bus_own | output | 1 | High while the block is driving the memory strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes, active low; bit 1 upper byte, bit 0 lower byte |

## Verification
The bench holds the grant low for much longer than MAX_PEND refresh intervals. A backlog without saturation would replay too many cycles when the grant returns, and one that dropped expiries would replay too few. It also drops the grant in the middle of cycles. A sequencer that obeys the grant mid-cycle would cut the row-low or precharge phase short, which the per-clock comparison of the strobes exposes. The pause length and the number of initialization cycles are measured on the ports twice, once after a second reset in the middle of the run. This catches off-by-one counters and a `ready` that rises one cycle early or does not restart.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    // Power-up stage of the sequencer.
    typedef enum logic [1:0] {
        ST_PAUSE = 2'd0,
        ST_INIT  = 2'd1,
        ST_RUN   = 2'd2
    } rfs_stage_e;

    // Phase of one column-before-row refresh cycle.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CAS  = 2'd1,
        PH_RAS  = 2'd2,
        PH_PRE  = 2'd3
    } rfs_phase_e;

endpackage

// File: rtl/rfs_init_ctrl.sv
module rfs_init_ctrl
    import rfs_pkg::*;
#(
    parameter int PAUSE_CYC = 20000,
    parameter int INIT_CNT  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_done,
    output logic init_want,
    output logic ready
);

    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int IW = $clog2(INIT_CNT + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
    localparam logic [IW-1:0] INIT_LOAD  = IW'(INIT_CNT);
    localparam logic [IW-1:0] INIT_ONE   = IW'(1);

    typedef struct packed {
        rfs_stage_e    stage;
        logic [PW-1:0] pcnt;
        logic [IW-1:0] left;
    } init_st_t;

    init_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.stage)
            ST_PAUSE: begin
                if (st_q.pcnt == PAUSE_LAST) begin
                    st_d.stage = ST_INIT;
                    st_d.left  = INIT_LOAD;
                end else begin
                    st_d.pcnt = st_q.pcnt + PW'(1);
                end
            end
            ST_INIT: begin
                if (cyc_done) begin
                    if (st_q.left == INIT_ONE) begin
                        st_d.stage = ST_RUN;
                    end
                    st_d.left = st_q.left - INIT_ONE;
                end
            end
            default: begin
                st_d.stage = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stage: ST_PAUSE, pcnt: '0, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign init_want = (st_q.stage == ST_INIT);
    assign ready     = (st_q.stage == ST_RUN);

endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog #(
    parameter int REF_INTERVAL = 1560,
    parameter int MAX_PEND     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cyc_done,
    output logic pend_nz
);

    localparam int TW = $clog2(REF_INTERVAL + 1);
    localparam int NW = $clog2(MAX_PEND + 1);
    localparam logic [TW-1:0] TMR_LAST = TW'(REF_INTERVAL - 1);
    localparam logic [NW-1:0] PEND_CAP = NW'(MAX_PEND);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic [NW-1:0] pend;
    } blog_st_t;

    blog_st_t st_d, st_q;
    logic     tick;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.tmr == TMR_LAST);

        if (!run || tick) begin
            st_d.tmr = '0;
        end else begin
            st_d.tmr = st_q.tmr + TW'(1);
        end

        unique case ({tick, cyc_done})
            2'b10: begin
                if (st_q.pend != PEND_CAP) begin
                    st_d.pend = st_q.pend + NW'(1);
                end
            end
            2'b01: begin
                if (st_q.pend != '0) begin
                    st_d.pend = st_q.pend - NW'(1);
                end
            end
            default: begin
                st_d.pend = st_q.pend;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{tmr: '0, pend: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_nz = (st_q.pend != '0);

endmodule

// File: rtl/rfs_cycle_fsm.sv
module rfs_cycle_fsm
    import rfs_pkg::*;
#(
    parameter int CAS_LEAD = 1,
    parameter int RAS_LOW  = 6,
    parameter int PRECH    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       want,
    input  logic       gnt,
    output logic       ras_n,
    output logic [1:0] cas_n,
    output logic       own,
    output logic       cyc_done
);

    localparam int LONG1   = (CAS_LEAD > RAS_LOW) ? CAS_LEAD : RAS_LOW;
    localparam int LONGEST = (LONG1 > PRECH) ? LONG1 : PRECH;
    localparam int CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] LEAD_LAST = CW'(CAS_LEAD - 1);
    localparam logic [CW-1:0] LOW_LAST  = CW'(RAS_LOW - 1);
    localparam logic [CW-1:0] PRE_LAST  = CW'(PRECH - 1);

    typedef struct packed {
        rfs_phase_e    ph;
        logic [CW-1:0] cnt;
    } cyc_st_t;

    cyc_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        cyc_done = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (want && gnt) begin
                    st_d.ph  = PH_CAS;
                    st_d.cnt = '0;
                end
            end
            PH_CAS: begin
                if (st_q.cnt == LEAD_LAST) begin
                    st_d.ph  = PH_RAS;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            PH_RAS: begin
                if (st_q.cnt == LOW_LAST) begin
                    st_d.ph  = PH_PRE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            PH_PRE: begin
                if (st_q.cnt == PRE_LAST) begin
                    st_d.ph  = PH_IDLE;
                    st_d.cnt = '0;
                    cyc_done = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // Both byte strobes share one source so they cannot diverge.
    logic cas_low;
    assign cas_low = (st_q.ph == PH_CAS) || (st_q.ph == PH_RAS);

    for (genvar b = 0; b < 2; b++) begin : g_cas
        assign cas_n[b] = ~cas_low;
    end

    assign ras_n = (st_q.ph != PH_RAS);
    assign own   = (st_q.ph != PH_IDLE);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int PAUSE_CYC    = 20000,
    parameter int INIT_CNT     = 8,
    parameter int REF_INTERVAL = 1560,
    parameter int MAX_PEND     = 8,
    parameter int CAS_LEAD     = 1,
    parameter int RAS_LOW      = 6,
    parameter int PRECH        = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_gnt,
    output logic       ref_req,
    output logic       ready,
    output logic       bus_own,
    output logic       ras_n,
    output logic [1:0] cas_n
);

    logic init_want;
    logic pend_nz;
    logic cyc_done;
    logic want;
    logic run_done;

    rfs_init_ctrl #(
        .PAUSE_CYC (PAUSE_CYC),
        .INIT_CNT  (INIT_CNT)
    ) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_done  (cyc_done),
        .init_want (init_want),
        .ready     (ready)
    );

    assign run_done = cyc_done && ready;

    rfs_backlog #(
        .REF_INTERVAL (REF_INTERVAL),
        .MAX_PEND     (MAX_PEND)
    ) u_backlog (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ready),
        .cyc_done (run_done),
        .pend_nz  (pend_nz)
    );

    assign want = init_want || pend_nz;

    rfs_cycle_fsm #(
        .CAS_LEAD (CAS_LEAD),
        .RAS_LOW  (RAS_LOW),
        .PRECH    (PRECH)
    ) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (want),
        .gnt      (ref_gnt),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .own      (bus_own),
        .cyc_done (cyc_done)
    );

    assign ref_req = want || bus_own;

endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_gnt,
    input logic       ref_req,
    input logic       ready,
    input logic       bus_own,
    input logic       ras_n,
    input logic [1:0] cas_n
);

    p_cas_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cas_n[0] == cas_n[1]);

    p_ras_under_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (cas_n == 2'b00));

    p_cas_leads_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(cas_n) == 2'b00));

    p_ready_sticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    p_own_keeps_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |-> ref_req);

    p_start_on_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own) |-> ($past(ref_gnt) && $past(ref_req)));

    p_strobes_owned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || (cas_n != 2'b11)) |-> bus_own);

endmodule

bind dram_refresh_sched rfs_sched_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_gnt (ref_gnt),
    .ref_req (ref_req),
    .ready   (ready),
    .bus_own (bus_own),
    .ras_n   (ras_n),
    .cas_n   (cas_n)
);

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;

    localparam int PAUSE_CYC    = 30;
    localparam int INIT_CNT     = 8;
    localparam int REF_INTERVAL = 40;
    localparam int MAX_PEND     = 8;
    localparam int CAS_LEAD     = 2;
    localparam int RAS_LOW      = 6;
    localparam int PRECH        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_gnt = 1'b0;
    logic       ref_req, ready, bus_own, ras_n;
    logic [1:0] cas_n;

    always #10 clk = ~clk;

    dram_refresh_sched #(
        .PAUSE_CYC    (PAUSE_CYC),
        .INIT_CNT     (INIT_CNT),
        .REF_INTERVAL (REF_INTERVAL),
        .MAX_PEND     (MAX_PEND),
        .CAS_LEAD     (CAS_LEAD),
        .RAS_LOW      (RAS_LOW),
        .PRECH        (PRECH)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_gnt (ref_gnt),
        .ref_req (ref_req),
        .ready   (ready),
        .bus_own (bus_own),
        .ras_n   (ras_n),
        .cas_n   (cas_n)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state: stage 0 pause, 1 init, 2 run; phase 0 idle, 1 cas, 2 ras, 3 pre.
    int m_stage, m_pcnt, m_left, m_pend, m_tmr, m_ph, m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stage = 0; m_pcnt = 0; m_left = 0;
            m_pend = 0; m_tmr = 0; m_ph = 0; m_cnt = 0;
        end else begin : model_step
            bit fin, due, need;
            int lim;
            fin  = (m_ph == 3) && (m_cnt == PRECH - 1);
            due  = (m_stage == 2) && (m_tmr == REF_INTERVAL - 1);
            need = (m_stage == 1) || (m_pend > 0);
            // backlog and timer
            if (m_stage == 2) begin
                if (due && !fin) m_pend = (m_pend < MAX_PEND) ? m_pend + 1 : m_pend;
                else if (fin && !due && m_pend > 0) m_pend = m_pend - 1;
                m_tmr = due ? 0 : m_tmr + 1;
            end else begin
                m_tmr = 0;
            end
            // power-up stage
            if (m_stage == 0) begin
                if (m_pcnt == PAUSE_CYC - 1) begin m_stage = 1; m_left = INIT_CNT; end
                else m_pcnt = m_pcnt + 1;
            end else if (m_stage == 1 && fin) begin
                m_left = m_left - 1;
                if (m_left == 0) m_stage = 2;
            end
            // refresh cycle phases
            lim = (m_ph == 1) ? CAS_LEAD : (m_ph == 2) ? RAS_LOW : PRECH;
            if (m_ph == 0) begin
                if (need && ref_gnt) begin m_ph = 1; m_cnt = 0; end
            end else if (m_cnt == lim - 1) begin
                m_ph = (m_ph == 3) ? 0 : m_ph + 1;
                m_cnt = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    int dut_falls = 0;
    int mdl_falls = 0;
    logic prev_ras = 1'b1;
    bit   prev_mras = 1'b1;

    always @(negedge clk) begin : compare
        bit e_ras, e_own, e_ready, e_req;
        logic [1:0] e_cas;
        e_ras   = (m_ph != 2);
        e_cas   = (m_ph == 1 || m_ph == 2) ? 2'b00 : 2'b11;
        e_own   = (m_ph != 0);
        e_ready = (m_stage == 2);
        e_req   = (m_stage == 1) || (m_pend > 0) || (m_ph != 0);
        checks++;
        if (!rst_n) begin
            if (ras_n !== 1'b1 || cas_n !== 2'b11 || ref_req !== 1'b0 ||
                ready !== 1'b0 || bus_own !== 1'b0) begin
                errors++;
                $display("FAIL R1 reset outputs ras=%b cas=%b req=%b rdy=%b own=%b expected 1 11 0 0 0",
                         ras_n, cas_n, ref_req, ready, bus_own);
            end
        end else begin
            if (ras_n !== e_ras) begin
                errors++;
                $display("FAIL R4 ras_n actual %b expected %b at %0t", ras_n, e_ras, $time);
            end
            if (cas_n !== e_cas) begin
                errors++;
                $display("FAIL R4/R5 cas_n actual %b expected %b at %0t", cas_n, e_cas, $time);
            end
            if (ref_req !== e_req) begin
                errors++;
                $display("FAIL R6 R7 R8 ref_req actual %b expected %b at %0t", ref_req, e_req, $time);
            end
            if (ready !== e_ready) begin
                errors++;
                $display("FAIL R3 R11 ready actual %b expected %b at %0t", ready, e_ready, $time);
            end
            if (bus_own !== e_own) begin
                errors++;
                $display("FAIL R9 R10 bus_own actual %b expected %b at %0t", bus_own, e_own, $time);
            end
        end
        if (prev_ras === 1'b1 && ras_n === 1'b0) dut_falls++;
        if (prev_mras && !e_ras) mdl_falls++;
        prev_ras  = ras_n;
        prev_mras = e_ras;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); #2 rst_n = 1'b0;
        repeat (4) @(negedge clk);
        #2 rst_n = 1'b1;
        dut_falls = 0;
        mdl_falls = 0;
    endtask

    task automatic power_up_checks();
        int n = 0;
        int spin = 0;
        while (n < PAUSE_CYC + 5) begin
            @(negedge clk); #1;
            n++;
            if (ref_req) break;
        end
        check(n == PAUSE_CYC, "R2 edges until first request", n, PAUSE_CYC);
        while (!ready && spin < 1000) begin
            @(negedge clk); #1;
            spin++;
        end
        check(dut_falls == INIT_CNT, "R3 init cycles before ready", dut_falls, INIT_CNT);
    endtask

    initial begin : main
        ref_gnt = 1'b1;
        repeat (3) @(negedge clk);
        // R1 is checked each cycle of reset by the compare process
        #2 rst_n = 1'b1;
        power_up_checks();

        // R6: steady refresh with the grant held
        @(negedge clk); #2;
        dut_falls = 0; mdl_falls = 0;
        repeat (400) @(negedge clk);
        #1;
        check(dut_falls >= 9 && dut_falls <= 11, "R6 refreshes in 400 cycles", dut_falls, 10);
        check(dut_falls == mdl_falls, "R6 refresh count vs model", dut_falls, mdl_falls);

        // R7: long denial builds a saturated backlog
        ref_gnt = 1'b0;
        repeat (600) @(negedge clk);
        #2;
        ref_gnt = 1'b1;
        dut_falls = 0; mdl_falls = 0;
        begin
            int spin = 0;
            @(negedge clk); #1;
            while (ref_req && spin < 400) begin
                @(negedge clk); #1;
                spin++;
            end
        end
        check(dut_falls == mdl_falls, "R7 backlog burst length", dut_falls, mdl_falls);
        check(dut_falls >= MAX_PEND && dut_falls <= MAX_PEND + 3, "R7 burst bounded by cap", dut_falls, MAX_PEND);

        // R9: grant toggling, dropped in the middle of cycles
        for (int i = 0; i < 600; i++) begin
            @(negedge clk); #2;
            ref_gnt = ((i % 3) == 0) || ((i % 7) == 1);
        end
        ref_gnt = 1'b1;
        repeat (100) @(negedge clk);

        // R3: second reset reruns the whole sequence
        do_reset();
        power_up_checks();
        repeat (200) @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule